// File: doc/BRIEF.md
# DDR SDRAM Power-Up Mode Programming Sequencer

This block walks a DDR1 or DDR2 SDRAM through its power-up mode-register programming after a start request. A memory-type strap picks one of two fixed command scripts. The block issues one command at a time as a single-cycle pulse on a one-hot command bus. A 14-bit mode value travels alongside each command, and a fixed number of idle cycles separates successive commands. When the script is finished, the block loads the refresh configuration value and raises a done flag. The refresh counter, the DRAM timing engine, the PHY and the data path sit outside this block and consume its outputs.

A second strap selects which refresh interval is loaded: one value for a 40 MHz reference clock and another for the slower clock. Both straps are sampled when the start request is accepted, so a change on a strap pin during a run has no effect until the next run. In DDR2 mode, the DDR2 configuration enable is asserted before the first command is issued.

The state machine has these states:
- `ST_IDLE` is the reset state.
- `ST_CFG` samples the straps and sets or clears the DDR2 enable.
- `ST_SETUP` puts the mode value on the bus one cycle ahead of the pulse.
- `ST_ISSUE` drives the one-cycle command pulse.
- `ST_GAP` waits out the inter-command gap.
- `ST_FINISH` loads the refresh value.
- `ST_DONE` holds the done flag.

The state transitions are:
- `ST_IDLE`/`ST_DONE` go to `ST_CFG` when start is high.
- `ST_CFG` goes to `ST_SETUP`.
- `ST_SETUP` goes to `ST_ISSUE`.
- `ST_ISSUE` goes to `ST_GAP`.
- `ST_GAP` goes to `ST_SETUP` when the gap has expired and steps remain.
- `ST_GAP` goes to `ST_FINISH` when the gap has expired after the last step.
- `ST_FINISH` goes to `ST_DONE`.

Top module: `ddr_init_seq`

## Requirements
- R1: `cmd_stb` is one-hot and each pulse lasts exactly one cycle. Its bit positions are:
  - bit0: mode register set
  - bit1: extended mode set
  - bit2: auto refresh
  - bit3: precharge all
  - bit4: extended mode 2 set
  - bit5: extended mode 3 set
- R2: With the DDR2 strap high, exactly these eleven (command, value) pairs are issued, in this order:
  1. (bit3, 0)
  2. (bit4, 0)
  3. (bit5, 0)
  4. (bit1, 0)
  5. (bit0, 0x100)
  6. (bit3, 0)
  7. (bit2, 0)
  8. (bit2, 0)
  9. (bit0, 0xA33)
  10. (bit1, 0x382)
  11. (bit1, 0x402)
- R3: With the DDR2 strap low, exactly these five pairs are issued, in this order:
  1. (bit3, 0)
  2. (bit0, 0x133)
  3. (bit1, 0x002)
  4. (bit3, 0)
  5. (bit0, 0x033)
- R4: Both straps are sampled when start is accepted. A strap change during a run has no effect on that run.
- R5: `ddr2_cfg_en` is high at the first command pulse of a DDR2 run, and low at the first pulse of a DDR1 run.
- R6: Between two successive command pulses of one run there are exactly GAP_CYCLES+1 cycles with no pulse. With the default GAP_CYCLES of 16, that is 17 cycles.
- R7: `mode_val` carries the command's value in the cycle before the pulse and in the pulse cycle. It is zero when neither applies.
- R8: When the run ends, `refresh_cfg` is loaded with the following fields, and `done` rises in the same cycle:
  - bit14: 1 (refresh enable)
  - bits13:10: 0
  - bits9:0: the interval, 624 when the 40 MHz strap is high and 390 otherwise
- R9: `busy` is high from the cycle after start is accepted until `done` rises. A start that arrives while `busy` is high is ignored. `done` stays high until the next start.
- R10: After reset the outputs are as follows:
  - `cmd_stb`: zero
  - `mode_val`: zero
  - `refresh_cfg`: zero
  - `ddr2_cfg_en`: low
  - `busy`: low
  - `done`: low

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is not busy |
| strap_ddr2 | input | 1 | Memory-type strap: 1 selects DDR2, 0 selects DDR1 |
| strap_ref40 | input | 1 | Reference clock strap: 1 means 40 MHz |
| cmd_stb | output | 6 | One-hot command pulse |
| mode_val | output | 14 | Mode value for the current command |
| ddr2_cfg_en | output | 1 | DDR2 configuration enable |
| refresh_cfg | output | 15 | Refresh enable and interval |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |

## Verification
The hardest situation to reach is a strap change or a second start request arriving in the middle of a run. These must be shown to leave the ordered command list, the DDR2 enable and the loaded refresh interval untouched. The stimulus covers this in two runs: forty cycles after start, it inverts both straps and pulses start again. The scoreboard then still expects the script and the refresh value chosen when the run began. A DDR1 run that follows a DDR2 run shows that the DDR2 enable is cleared again.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
    localparam int CMD_W = 6;
    localparam int MODE_W = 14;
    localparam int REF_W = 15;
    localparam int IVL_W = 10;
    localparam int IDX_W = 4;

    localparam int C_MRS = 0;
    localparam int C_EMRS = 1;
    localparam int C_AREF = 2;
    localparam int C_PREA = 3;
    localparam int C_EMR2 = 4;
    localparam int C_EMR3 = 5;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [MODE_W-1:0] val;
        logic last;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_SETUP,
        ST_ISSUE,
        ST_GAP,
        ST_FINISH,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/ddr_init_script.sv
module ddr_init_script
    import ddr_init_pkg::*;
(
    input  logic             ddr2,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    function automatic logic [CMD_W-1:0] oh(input int b);
        return CMD_W'(1) << b;
    endfunction

    always_comb begin
        step = '0;
        if (ddr2) begin
            case (idx)
                4'd0:  step = '{oh(C_PREA), 14'h000, 1'b0};
                4'd1:  step = '{oh(C_EMR2), 14'h000, 1'b0};
                4'd2:  step = '{oh(C_EMR3), 14'h000, 1'b0};
                4'd3:  step = '{oh(C_EMRS), 14'h000, 1'b0};
                4'd4:  step = '{oh(C_MRS),  14'h100, 1'b0};
                4'd5:  step = '{oh(C_PREA), 14'h000, 1'b0};
                4'd6:  step = '{oh(C_AREF), 14'h000, 1'b0};
                4'd7:  step = '{oh(C_AREF), 14'h000, 1'b0};
                4'd8:  step = '{oh(C_MRS),  14'hA33, 1'b0};
                4'd9:  step = '{oh(C_EMRS), 14'h382, 1'b0};
                4'd10: step = '{oh(C_EMRS), 14'h402, 1'b1};
                default: step = '{'0, '0, 1'b1};
            endcase
        end else begin
            case (idx)
                4'd0:  step = '{oh(C_PREA), 14'h000, 1'b0};
                4'd1:  step = '{oh(C_MRS),  14'h133, 1'b0};
                4'd2:  step = '{oh(C_EMRS), 14'h002, 1'b0};
                4'd3:  step = '{oh(C_PREA), 14'h000, 1'b0};
                4'd4:  step = '{oh(C_MRS),  14'h033, 1'b1};
                default: step = '{'0, '0, 1'b1};
            endcase
        end
    end
endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
    parameter int GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= GAP_W'(GAP_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int GAP_CYCLES = 16,
    parameter int REF_IVL_FAST = 624,
    parameter int REF_IVL_SLOW = 390
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    output logic [CMD_W-1:0]  cmd_stb,
    output logic [MODE_W-1:0] mode_val,
    output logic              ddr2_cfg_en,
    output logic [REF_W-1:0]  refresh_cfg,
    output logic              busy,
    output logic              done
);
    localparam int REF_EN_BIT = REF_W - 1;

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             ddr2_q, ref40_q;
    step_t            step;
    logic             gap_expired;

    ddr_init_script u_script (
        .ddr2(ddr2_q),
        .idx (idx_q),
        .step(step)
    );

    ddr_init_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_ISSUE),
        .expired(gap_expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_CFG;
            ST_CFG:    state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_GAP;
            ST_GAP: begin
                if (gap_expired) state_d = step.last ? ST_FINISH : ST_SETUP;
            end
            ST_FINISH: state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register, step index and sampled straps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE || state_q == ST_DONE) && start) begin
                idx_q   <= '0;
                ddr2_q  <= strap_ddr2;
                ref40_q <= strap_ref40;
            end else if (state_q == ST_GAP && gap_expired && !step.last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr2_cfg_en <= 1'b0;
            refresh_cfg <= '0;
        end else begin
            if (state_q == ST_CFG) ddr2_cfg_en <= ddr2_q;
            if (state_q == ST_FINISH) begin
                refresh_cfg             <= '0;
                refresh_cfg[REF_EN_BIT] <= 1'b1;
                refresh_cfg[IVL_W-1:0]  <= ref40_q ? IVL_W'(REF_IVL_FAST)
                                                   : IVL_W'(REF_IVL_SLOW);
            end
        end
    end

    assign cmd_stb  = (state_q == ST_ISSUE) ? step.cmd : '0;
    assign mode_val = (state_q == ST_SETUP || state_q == ST_ISSUE) ? step.val : '0;
    assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
    import ddr_init_pkg::*;
#(
    parameter int GAP_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CMD_W-1:0]  cmd_stb,
    input logic [MODE_W-1:0] mode_val,
    input logic [REF_W-1:0]  refresh_cfg,
    input logic              busy,
    input logic              done
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 4);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] since_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (cmd_stb != '0) begin
                since_q <= '0;
                seen_q  <= 1'b1;
            end else if (since_q != CNT_MAX) begin
                since_q <= since_q + 1'b1;
            end
            if (!busy) seen_q <= 1'b0;
        end
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_stb));
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb != '0) |=> (cmd_stb == '0));
    a_r7_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb != '0) |-> $stable(mode_val));
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb != '0 && seen_q) |-> (since_q == CNT_W'(GAP_CYCLES + 1)));
    a_r9_stb_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb != '0) |-> busy);
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_refresh_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_cfg) |-> (done && refresh_cfg[REF_W-1]));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .mode_val   (mode_val),
    .refresh_cfg(refresh_cfg),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
    localparam int GAP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic [5:0]  cmd_stb;
    logic [13:0] mode_val;
    logic        ddr2_cfg_en;
    logic [14:0] refresh_cfg;
    logic        busy, done;

    int checks = 0;
    int failures = 0;
    logic [19:0] exp_q[$];
    logic        exp_ddr2 = 1'b0;
    logic [13:0] prev_val = '0;
    int          since = 0;
    bit          have_prev = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    ddr_init_seq #(.GAP_CYCLES(GAP)) i_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .strap_ddr2(strap_ddr2), .strap_ref40(strap_ref40),
        .cmd_stb(cmd_stb), .mode_val(mode_val), .ddr2_cfg_en(ddr2_cfg_en),
        .refresh_cfg(refresh_cfg), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver side: expected script pushed into the scoreboard
    task automatic push_script(input bit ddr2);
        if (ddr2) begin
            exp_q.push_back({6'h08, 14'h000});
            exp_q.push_back({6'h10, 14'h000});
            exp_q.push_back({6'h20, 14'h000});
            exp_q.push_back({6'h02, 14'h000});
            exp_q.push_back({6'h01, 14'h100});
            exp_q.push_back({6'h08, 14'h000});
            exp_q.push_back({6'h04, 14'h000});
            exp_q.push_back({6'h04, 14'h000});
            exp_q.push_back({6'h01, 14'hA33});
            exp_q.push_back({6'h02, 14'h382});
            exp_q.push_back({6'h02, 14'h402});
        end else begin
            exp_q.push_back({6'h08, 14'h000});
            exp_q.push_back({6'h01, 14'h133});
            exp_q.push_back({6'h02, 14'h002});
            exp_q.push_back({6'h08, 14'h000});
            exp_q.push_back({6'h01, 14'h033});
        end
    endtask

    // Monitor: pops and compares each command pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string tag;
            tag = exp_ddr2 ? "R2" : "R3";
            if (cmd_stb != '0) begin
                check($countones(cmd_stb) == 1, "R1 onehot", 32'(cmd_stb), 32'h1);
                check(prev_val == mode_val, "R7 value before pulse", 32'(prev_val),
                      32'(mode_val));
                if (have_prev)
                    check(since == GAP + 1, "R6 gap", 32'(since), 32'(GAP + 1));
                else
                    check(ddr2_cfg_en == exp_ddr2, "R5 cfg enable", 32'(ddr2_cfg_en),
                          32'(exp_ddr2));
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " unexpected command"}, {12'h0, cmd_stb, mode_val},
                          32'h0);
                end else begin
                    logic [19:0] e;
                    e = exp_q.pop_front();
                    check({cmd_stb, mode_val} == e, {tag, " command/value"},
                          {12'h0, cmd_stb, mode_val}, {12'h0, e});
                end
                have_prev = 1;
                since = 0;
            end else begin
                since++;
                if (!busy)
                    check(mode_val == '0, "R7 value idle", 32'(mode_val), 32'h0);
            end
            prev_val = mode_val;
            if (!busy) have_prev = 0;
        end
    end

    task automatic run(input bit ddr2, input bit r40, input bit disturb);
        int n;
        push_script(ddr2);
        @(negedge clk);
        exp_ddr2 = ddr2;
        strap_ddr2 = ddr2;
        strap_ref40 = r40;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R9 busy after start", 32'({busy, done}),
              32'h2);
        if (disturb) begin
            repeat (40) @(negedge clk);
            strap_ddr2 = ~ddr2;   // R4: must not affect this run
            strap_ref40 = ~r40;
            start = 1'b1;         // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9 done reached", 32'(done), 32'h1);
        check(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'h0);
        check(refresh_cfg == {1'b1, 4'h0, (r40 ? 10'd624 : 10'd390)}, "R8 refresh value",
              32'(refresh_cfg), 32'({1'b1, 4'h0, (r40 ? 10'd624 : 10'd390)}));
        check(exp_q.size() == 0, ddr2 ? "R2 all issued" : "R3 all issued",
              32'(exp_q.size()), 32'h0);
        check(ddr2_cfg_en == ddr2, "R5 cfg after run", 32'(ddr2_cfg_en), 32'(ddr2));
        if (disturb) strap_ddr2 = ddr2;
        repeat (30) @(negedge clk);
        check(done == 1'b1 && refresh_cfg[14], "R9 done holds", 32'(done), 32'h1);
        check(exp_q.size() == 0, "R4 no extra commands", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_stb == '0 && mode_val == '0, "R10 reset bus", {12'h0, cmd_stb, mode_val},
              32'h0);
        check(refresh_cfg == '0 && !ddr2_cfg_en, "R10 reset config",
              32'({ddr2_cfg_en, refresh_cfg}), 32'h0);
        check(!busy && !done, "R10 reset flags", 32'({busy, done}), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cmd_stb == '0 && !busy, "R10 idle without start", 32'({busy, cmd_stb}),
              32'h0);
        run(1'b1, 1'b1, 1'b0);
        run(1'b0, 1'b0, 1'b1);
        run(1'b1, 1'b0, 1'b1);
        run(1'b0, 1'b1, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule